// File: doc/BRIEF.md
# ATA Command Issue Sequencer

This block issues a single ATA command to a drive through an 8-bit taskfile register port. A request carries the direction (read or write), the transfer kind (PIO or DMA), a 48-bit starting LBA, a 16-bit sector count and the target device. The sequencer then works through the issue procedure. It waits until the drive is not busy and selects the device. If the selection changed, it waits for the bus to settle. It fills in the taskfile and writes the command opcode last. Moving the data, driving a DMA engine and servicing interrupts belong to other blocks.

The sequencer decides for itself whether the request needs the extended 48-bit form. The extended form is used when the count does not fit in one byte or the last sector lies beyond the 28-bit space. In that case the high-order bytes go to the taskfile ahead of the low-order bytes. Each register access is a single-outstanding request/acknowledge transfer with a 4-bit address. A busy poll gives up after a programmable number of cycles. It then flags an error and never writes the command register.

Top module: `ata_cmd_issuer`

## Requirements
- R1: After reset `req_ready` is 1, and `rg_req`, `done` and `timeout_err` are 0; while `req_ready` is 1 no register access is requested.
- R2: The first access after a request is accepted is a read of address 7 (status). The status read repeats, with no other access in between, until a read returns bit 7 (busy) clear.
- R3: Next comes a read of address 6 (device/head), then a write to address 6. The value written is 0x40, plus 0x10 when `req_dev` is 1, plus LBA[27:24] in bits 3:0 in 28-bit mode only.
- R4: If bit 4 of the written device byte differs from bit 4 of the byte read, at least SETTLE_CYCLES cycles pass with no access. Status is then polled again as in R2 before any taskfile write. If bit 4 is unchanged, the first taskfile write follows the device write directly.
- R5: The extended (48-bit) form is chosen exactly when the count is 256 or more, or when LBA + count is at least 2^28.
- R6: In extended form, ten taskfile writes go to addresses 1,2,3,4,5 and then again 1,2,3,4,5. The first pass carries 0, count[15:8], LBA[31:24], LBA[39:32] and LBA[47:40]. The second pass carries 0, count[7:0], LBA[7:0], LBA[15:8] and LBA[23:16].
- R7: In 28-bit form only the second pass of R6 is written, carrying the low bytes of the count and the LBA.
- R8: The last access is a write of the opcode to address 7. The opcode is 0x20 for a PIO read, 0x30 for a PIO write, 0xC8 for a DMA read and 0xCA for a DMA write. The extended forms are 0x24, 0x34, 0x25 and 0x35.
- R9: `done` pulses for one cycle in the cycle after the command write is acknowledged. In that same cycle `req_ready` is 1 and a new request can be accepted.
- R10: A status read that returns busy after `poll_limit` or more cycles in the current poll ends the command. `timeout_err` pulses for one cycle and the sequencer returns to idle with no further access. A read with busy clear always proceeds, even if the limit has been reached.
- R11: `req_valid` has no effect while `req_ready` is 0; the accesses of the command in progress are unchanged.
- R12: While `rg_req` is 1 and `rg_ack` is 0, `rg_we`, `rg_addr` and `rg_wdata` hold their values into the next cycle; an access completes on a cycle with both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | 1 = DMA opcode, 0 = PIO opcode |
| req_lba | input | 48 | Starting logical block address |
| req_count | input | 16 | Sector count |
| req_dev | input | 1 | Target device (0 or 1) |
| poll_limit | input | 16 | Busy poll timeout in cycles |
| req_ready | output | 1 | Idle, request accepted when `req_valid` is 1 |
| done | output | 1 | One-cycle pulse: command issued |
| timeout_err | output | 1 | One-cycle pulse: busy poll timed out |
| rg_req | output | 1 | Register access request |
| rg_we | output | 1 | Access is a write |
| rg_addr | output | 4 | Taskfile register address |
| rg_wdata | output | 8 | Write data |
| rg_ack | input | 1 | Access completes this cycle |
| rg_rdata | input | 8 | Read data, valid with `rg_ack` |

## Verification
Two functions can meet in one cycle. The first pair is the timeout limit being reached and a status read returning busy clear. The bench provokes this with a limit of zero against a drive that is not busy, and judges it by the full command going out with no error. The second pair is the end of one command (`done`) and the acceptance of the next. The bench holds a second request valid across the first command. It judges that the second request is taken in the `done` cycle and that both access sequences appear back to back, unchanged.

// File: rtl/ata_issue_pkg.sv
// Shared widths, register addresses, opcodes and types for the ATA
// command issue sequencer. Assumes the conventional taskfile layout.
package ata_issue_pkg;
    localparam int LBA_W    = 48;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 4;
    localparam int IDX_W    = 4;
    localparam int TF_SLOTS = 5;            // feature, count, three LBA bytes
    localparam int TF_LAST  = 2 * TF_SLOTS - 1;
    localparam int EXT_CNT  = 256;
    localparam int LBA28_W  = 28;

    localparam logic [ADDR_W-1:0] TF_FEAT = 4'd1;
    localparam logic [ADDR_W-1:0] TF_DEVH = 4'd6;
    localparam logic [ADDR_W-1:0] TF_STAT = 4'd7;   // read side
    localparam logic [ADDR_W-1:0] TF_CMD  = 4'd7;   // write side

    localparam logic [7:0] DEV_LBA_BIT = 8'h40;
    localparam logic [7:0] DEV_SEL_BIT = 8'h10;
    localparam int         BSY_BIT     = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_POLL_A, ST_DEV_RD, ST_DEV_WR,
        ST_SETTLE, ST_POLL_B, ST_TASKFILE, ST_CMD
    } seq_state_t;

    typedef struct packed {
        logic             wr;
        logic             dma;
        logic [LBA_W-1:0] lba;
        logic [CNT_W-1:0] cnt;
        logic             dev;
    } issue_req_t;
endpackage

// File: rtl/ata_issue_decode.sv
// Combinational request decoder: picks 28/48-bit form, the opcode, the
// device byte and the address/data of taskfile write number idx.
// Assumes idx runs 0..TF_LAST, the first TF_SLOTS being the high pass.
module ata_issue_decode
    import ata_issue_pkg::*;
(
    input  issue_req_t        rq,
    input  logic [IDX_W-1:0]  idx,
    output logic              ext,
    output logic [7:0]        opcode,
    output logic [7:0]        dev_byte,
    output logic [ADDR_W-1:0] tf_addr,
    output logic [7:0]        tf_data,
    output logic [IDX_W-1:0]  first_idx
);
    logic [LBA_W:0]   reach;
    logic             hi_pass;
    logic [IDX_W-1:0] slot;

    // Addressing form: count above one byte or end beyond 28-bit space
    always_comb begin
        reach = {1'b0, rq.lba} + (LBA_W+1)'(rq.cnt);
        ext   = (rq.cnt >= CNT_W'(EXT_CNT)) || (reach[LBA_W:LBA28_W] != '0);
    end

    // Opcode selection from {dma, write, extended}
    always_comb begin
        unique case ({rq.dma, rq.wr, ext})
            3'b000:  opcode = 8'h20;
            3'b001:  opcode = 8'h24;
            3'b010:  opcode = 8'h30;
            3'b011:  opcode = 8'h34;
            3'b100:  opcode = 8'hC8;
            3'b101:  opcode = 8'h25;
            3'b110:  opcode = 8'hCA;
            default: opcode = 8'h35;
        endcase
    end

    // Device/head byte: LBA mode, device select, upper nibble in 28-bit form
    always_comb begin
        dev_byte = DEV_LBA_BIT | (rq.dev ? DEV_SEL_BIT : 8'h00)
                 | (ext ? 8'h00 : {4'h0, rq.lba[27:24]});
        first_idx = ext ? '0 : IDX_W'(TF_SLOTS);
    end

    // Taskfile slot: register address and byte for the current write
    always_comb begin
        hi_pass = (idx < IDX_W'(TF_SLOTS));
        slot    = hi_pass ? idx : idx - IDX_W'(TF_SLOTS);
        tf_addr = TF_FEAT + ADDR_W'(slot);
        unique case (slot)
            4'd0:    tf_data = 8'h00;
            4'd1:    tf_data = hi_pass ? rq.cnt[15:8]  : rq.cnt[7:0];
            4'd2:    tf_data = hi_pass ? rq.lba[31:24] : rq.lba[7:0];
            4'd3:    tf_data = hi_pass ? rq.lba[39:32] : rq.lba[15:8];
            default: tf_data = hi_pass ? rq.lba[47:40] : rq.lba[23:16];
        endcase
    end
endmodule

// File: rtl/ata_issue_timer.sv
// Saturating cycle counter. Cleared while clear is high, otherwise counts
// up to limit; expired is high once the count has reached limit.
module ata_issue_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt >= limit);

    // Count elapsed cycles, holding once the limit is reached
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (!expired)   cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/ata_cmd_issuer.sv
// ATA command issue sequencer. Polls busy, selects the device, waits for
// settle on a device change, writes the taskfile and then the command.
// Assumes one register access outstanding at a time; an access completes
// on a cycle where rg_req and rg_ack are both high.
module ata_cmd_issuer
    import ata_issue_pkg::*;
#(
    parameter int TMO_W         = 16,
    parameter int SETTLE_CYCLES = 20    // 400 ns at 50 MHz
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_dma,
    input  logic [LBA_W-1:0]  req_lba,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_dev,
    input  logic [TMO_W-1:0]  poll_limit,
    output logic              req_ready,
    output logic              done,
    output logic              timeout_err,
    output logic              rg_req,
    output logic              rg_we,
    output logic [ADDR_W-1:0] rg_addr,
    output logic [7:0]        rg_wdata,
    input  logic              rg_ack,
    input  logic [7:0]        rg_rdata
);
    localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);

    seq_state_t        state;
    issue_req_t        rq_q;
    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        old_dev_q;
    logic              ext;
    logic [7:0]        opcode, dev_byte, tf_data;
    logic [ADDR_W-1:0] tf_addr;
    logic [IDX_W-1:0]  first_idx;
    logic              take, busy_seen, poll_expired, settle_done, dev_moved;

    ata_issue_decode u_decode (
        .rq(rq_q), .idx(idx_q), .ext(ext), .opcode(opcode),
        .dev_byte(dev_byte), .tf_addr(tf_addr), .tf_data(tf_data),
        .first_idx(first_idx)
    );

    ata_issue_timer #(.W(TMO_W)) u_poll_tmr (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_IDLE || state == ST_SETTLE),
        .limit(poll_limit), .expired(poll_expired)
    );

    ata_issue_timer #(.W(SETTLE_W)) u_settle_tmr (
        .clk(clk), .rst_n(rst_n),
        .clear(state != ST_SETTLE),
        .limit(SETTLE_W'(SETTLE_CYCLES)), .expired(settle_done)
    );

    assign req_ready = (state == ST_IDLE);
    assign take      = rg_req && rg_ack;
    assign busy_seen = rg_rdata[BSY_BIT];
    assign dev_moved = |((old_dev_q ^ dev_byte) & DEV_SEL_BIT);

    // Register access driven by the current state
    always_comb begin
        rg_req   = 1'b1;
        rg_we    = 1'b0;
        rg_addr  = TF_STAT;
        rg_wdata = 8'h00;
        unique case (state)
            ST_IDLE, ST_SETTLE:  rg_req = 1'b0;
            ST_POLL_A, ST_POLL_B: ;
            ST_DEV_RD:           rg_addr = TF_DEVH;
            ST_DEV_WR:   begin rg_we = 1'b1; rg_addr = TF_DEVH; rg_wdata = dev_byte; end
            ST_TASKFILE: begin rg_we = 1'b1; rg_addr = tf_addr; rg_wdata = tf_data;  end
            default:     begin rg_we = 1'b1; rg_addr = TF_CMD;  rg_wdata = opcode;   end
        endcase
    end

    // Issue sequence state machine with done / timeout pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            rq_q        <= '0;
            idx_q       <= '0;
            old_dev_q   <= '0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            done        <= 1'b0;
            timeout_err <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    rq_q  <= '{wr: req_write, dma: req_dma, lba: req_lba,
                               cnt: req_count, dev: req_dev};
                    state <= ST_POLL_A;
                end
                ST_POLL_A, ST_POLL_B: if (take) begin
                    if (!busy_seen) begin
                        state <= (state == ST_POLL_A) ? ST_DEV_RD : ST_TASKFILE;
                        idx_q <= first_idx;
                    end else if (poll_expired) begin
                        timeout_err <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                ST_DEV_RD: if (take) begin
                    old_dev_q <= rg_rdata;
                    state     <= ST_DEV_WR;
                end
                ST_DEV_WR: if (take) begin
                    state <= dev_moved ? ST_SETTLE : ST_TASKFILE;
                    idx_q <= first_idx;
                end
                ST_SETTLE: if (settle_done) state <= ST_POLL_B;
                ST_TASKFILE: if (take) begin
                    if (idx_q == IDX_W'(TF_LAST)) state <= ST_CMD;
                    else                          idx_q <= idx_q + IDX_W'(1);
                end
                default: if (take) begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ata_cmd_issuer_chk.sv
// Protocol checker for ata_cmd_issuer, attached by bind. Observes ports only.
module ata_cmd_issuer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic       timeout_err,
    input logic       rg_req,
    input logic       rg_we,
    input logic [3:0] rg_addr,
    input logic [7:0] rg_wdata,
    input logic       rg_ack,
    input logic [7:0] rg_rdata
);
    // Idle means no access in flight
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rg_req);

    // Accepted request starts with a status read
    p_first_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (rg_req && !rg_we && rg_addr == 4'd7));

    // Command write completion is followed by done
    p_cmd_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_req && rg_ack && rg_we && rg_addr == 4'd7) |=> done);

    // done only after a completed command write
    p_done_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rg_req && rg_ack && rg_we && rg_addr == 4'd7));

    // Timeout only after a completed status read that showed busy
    p_err_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> $past(rg_req && rg_ack && !rg_we && rg_addr == 4'd7 && rg_rdata[7]));

    // Never both outcomes at once
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, timeout_err}));

    // Pending access holds its fields
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_req && !rg_ack) |=> (rg_req && $stable(rg_we) && $stable(rg_addr) && $stable(rg_wdata)));
endmodule

bind ata_cmd_issuer ata_cmd_issuer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .timeout_err(timeout_err), .rg_req(rg_req), .rg_we(rg_we),
    .rg_addr(rg_addr), .rg_wdata(rg_wdata), .rg_ack(rg_ack), .rg_rdata(rg_rdata)
);

// File: tb/ata_cmd_issuer_bench.sv
// Bench: drive model with random ack latency, logs every completed access
// and compares it to a sequence built from the requirements.
module ata_cmd_issuer_bench;
    localparam int SETTLE = 20;
    localparam int LOGN   = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_dma = 1'b0, req_dev = 1'b0;
    logic [47:0] req_lba = '0;
    logic [15:0] req_count = '0;
    logic [15:0] poll_limit = 16'hFFFF;
    logic        req_ready, done, timeout_err, rg_req, rg_we, rg_ack;
    logic [3:0]  rg_addr;
    logic [7:0]  rg_wdata, rg_rdata;

    always #10 clk = ~clk;   // 50 MHz

    ata_cmd_issuer #(.SETTLE_CYCLES(SETTLE)) u_ata_cmd_issuer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_dma(req_dma), .req_lba(req_lba), .req_count(req_count), .req_dev(req_dev),
        .poll_limit(poll_limit), .req_ready(req_ready), .done(done),
        .timeout_err(timeout_err), .rg_req(rg_req), .rg_we(rg_we), .rg_addr(rg_addr),
        .rg_wdata(rg_wdata), .rg_ack(rg_ack), .rg_rdata(rg_rdata)
    );

    int total = 0, bad = 0;
    int cfg_b1 = 0, cfg_b2 = 0;

    // Drive model and monitor state
    logic [7:0] dev_reg;
    int busy_left, lat, cyc;
    bit log_we[LOGN];
    logic [3:0] log_addr[LOGN];
    logic [7:0] log_data[LOGN];
    int log_t[LOGN];
    int log_n, done_n, err_n, acc_n, acc_on_done, hold_viol;
    bit pend;
    logic p_we; logic [3:0] p_addr; logic [7:0] p_wdata;

    // Drive model: random latency, busy status, device register, access log
    always @(posedge clk) begin
        logic [7:0] rv;
        cyc <= cyc + 1;
        if (!rst_n) begin
            rg_ack <= 1'b0; rg_rdata <= 8'h00; dev_reg <= 8'h00; busy_left <= 0;
            lat <= 1; log_n <= 0; pend <= 1'b0;
        end else begin
            if (req_ready && req_valid) busy_left <= cfg_b1;
            if (rg_ack) begin
                rg_ack <= 1'b0;
                pend   <= 1'b0;
            end else if (rg_req) begin
                if (pend && (rg_we != p_we || rg_addr != p_addr || rg_wdata != p_wdata))
                    hold_viol <= hold_viol + 1;
                pend <= 1'b1; p_we <= rg_we; p_addr <= rg_addr; p_wdata <= rg_wdata;
                if (lat != 0) lat <= lat - 1;
                else begin
                    rv = 8'h00;
                    if (!rg_we && rg_addr == 4'd7) begin
                        if (busy_left > 0) begin
                            rv = 8'h80 | 8'($urandom & 32'h7F);
                            busy_left <= busy_left - 1;
                        end else rv = 8'($urandom & 32'h7F);
                    end else if (!rg_we && rg_addr == 4'd6) rv = dev_reg;
                    if (rg_we && rg_addr == 4'd6) begin
                        dev_reg <= rg_wdata;
                        if (rg_wdata[4] != dev_reg[4]) busy_left <= cfg_b2;
                    end
                    rg_ack <= 1'b1; rg_rdata <= rv;
                    lat <= int'($urandom_range(3, 0));
                    log_we[log_n] <= rg_we; log_addr[log_n] <= rg_addr;
                    log_data[log_n] <= rg_we ? rg_wdata : rv; log_t[log_n] <= cyc;
                    log_n <= log_n + 1;
                end
            end
        end
    end

    // Outcome monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            done_n <= 0; err_n <= 0; acc_n <= 0; acc_on_done <= 0;
        end else begin
            if (done) done_n <= done_n + 1;
            if (timeout_err) err_n <= err_n + 1;
            if (req_ready && req_valid) acc_n <= acc_n + 1;
            if (done && req_ready && req_valid) acc_on_done <= acc_on_done + 1;
        end
    end

    // Expected access list
    bit exp_we[256]; logic [3:0] exp_addr[256]; logic [7:0] exp_data[256];
    bit exp_settle[256]; string exp_tag[256];
    int exp_n; bit cur_dev;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit ref_ext(input logic [47:0] lba, input logic [15:0] cnt);
        logic [48:0] e = {1'b0, lba} + {33'b0, cnt};
        return (cnt >= 16'd256) || (e >= 49'h1000_0000);
    endfunction

    function automatic logic [7:0] ref_op(input bit wr, input bit dma, input bit ext);
        if (!dma) return ext ? (wr ? 8'h34 : 8'h24) : (wr ? 8'h30 : 8'h20);
        return ext ? (wr ? 8'h35 : 8'h25) : (wr ? 8'hCA : 8'hC8);
    endfunction

    task automatic push(input bit we, input logic [3:0] a, input logic [7:0] d, input string tag);
        exp_we[exp_n] = we; exp_addr[exp_n] = a; exp_data[exp_n] = d;
        exp_tag[exp_n] = tag; exp_settle[exp_n] = 1'b0; exp_n++;
    endtask

    task automatic build(input bit wr, input bit dma, input logic [47:0] lba,
                         input logic [15:0] cnt, input bit dev, input int b1, input int b2);
        bit x = ref_ext(lba, cnt);
        logic [7:0] hi[5], lo[5];
        hi = '{8'h00, cnt[15:8], lba[31:24], lba[39:32], lba[47:40]};
        lo = '{8'h00, cnt[7:0], lba[7:0], lba[15:8], lba[23:16]};
        for (int i = 0; i <= b1; i++) push(1'b0, 4'd7, 8'h00, "R2");
        push(1'b0, 4'd6, 8'h00, "R3");
        push(1'b1, 4'd6, 8'h40 | (dev ? 8'h10 : 8'h00) | (x ? 8'h00 : {4'h0, lba[27:24]}), "R3");
        if (dev != cur_dev) begin
            exp_settle[exp_n] = 1'b1;
            for (int i = 0; i <= b2; i++) begin
                push(1'b0, 4'd7, 8'h00, "R4");
                if (i == 0) exp_settle[exp_n-1] = 1'b1;
            end
        end
        cur_dev = dev;
        if (x) for (int i = 0; i < 5; i++) push(1'b1, 4'(i + 1), hi[i], "R6");
        for (int i = 0; i < 5; i++) push(1'b1, 4'(i + 1), lo[i], x ? "R6" : "R7");
        push(1'b1, 4'd7, ref_op(wr, dma, x), "R8");
    endtask

    task automatic drive(input bit wr, input bit dma, input logic [47:0] lba,
                         input logic [15:0] cnt, input bit dev);
        req_write = wr; req_dma = dma; req_lba = lba; req_count = cnt; req_dev = dev;
    endtask

    task automatic wait_outcomes(input int target, input int d0, input int e0);
        int n = 0;
        while ((done_n - d0) + (err_n - e0) < target && n < 5000) begin
            @(negedge clk); n++;
        end
        if (n >= 5000) check(1'b0, "R9", "watchdog expired", n, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_log(input int base);
        check(log_n - base == exp_n, "R5", "access count", log_n - base, exp_n);
        for (int k = 0; k < exp_n && base + k < log_n; k++) begin
            int j = base + k;
            check(log_we[j] == exp_we[k] && log_addr[j] == exp_addr[k] &&
                  (!exp_we[k] || log_data[j] == exp_data[k]), exp_tag[k], "access",
                  {log_we[j], log_addr[j], log_data[j]}, {exp_we[k], exp_addr[k], exp_data[k]});
            if (exp_settle[k] && k > 0)
                check(log_t[j] - log_t[j-1] > SETTLE, "R4", "settle gap",
                      log_t[j] - log_t[j-1], SETTLE + 1);
        end
    endtask

    task automatic run_cmd(input bit wr, input bit dma, input logic [47:0] lba,
                           input logic [15:0] cnt, input bit dev, input int b1, input int b2);
        int base, d0, e0;
        @(negedge clk);
        base = log_n; d0 = done_n; e0 = err_n; exp_n = 0;
        cfg_b1 = b1; cfg_b2 = b2; poll_limit = 16'hFFFF;
        build(wr, dma, lba, cnt, dev, b1, b2);
        drive(wr, dma, lba, cnt, dev); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        wait_outcomes(1, d0, e0);
        compare_log(base);
        check(done_n - d0 == 1 && err_n == e0, "R9", "done pulses", done_n - d0, 1);
        check(req_ready, "R9", "ready after done", req_ready, 1);
    endtask

    initial begin
        int base, d0, e0, a0, ad0;
        void'($urandom(32'd1357));
        cur_dev = 1'b0;
        repeat (3) @(negedge clk);
        check(req_ready && !rg_req && !done && !timeout_err, "R1", "reset outputs",
              {req_ready, rg_req, done, timeout_err}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rg_req, "R1", "idle after reset", {req_ready, rg_req}, 2'b10);

        // Directed: 28-bit PIO read, same device, busy twice
        run_cmd(1'b0, 1'b0, 48'h0_0123456, 16'd1, 1'b0, 2, 0);
        // Device change with settle and second busy poll, DMA write
        run_cmd(1'b1, 1'b1, 48'h0_0ABCDEF, 16'd8, 1'b1, 0, 3);
        // Extended by count
        run_cmd(1'b0, 1'b1, 48'h0000_0000_0010, 16'd256, 1'b1, 1, 0);
        // Count 255 stays 28-bit
        run_cmd(1'b1, 1'b0, 48'h0000_0000_0010, 16'd255, 1'b1, 0, 0);
        // Boundary: end reaches 2^28 -> extended; one below -> 28-bit
        run_cmd(1'b1, 1'b0, 48'h0000_0FFF_FFFF, 16'd1, 1'b0, 0, 1);
        run_cmd(1'b0, 1'b0, 48'h0000_0FFF_FFFE, 16'd1, 1'b0, 0, 0);
        // Full 48-bit address
        run_cmd(1'b1, 1'b1, 48'hA1B2_C3D4_E5F6, 16'h1234, 1'b0, 0, 0);

        // R10: timeout while busy; no write reaches the drive
        @(negedge clk);
        base = log_n; d0 = done_n; e0 = err_n;
        cfg_b1 = 60; poll_limit = 16'd5;
        drive(1'b0, 1'b0, 48'h55, 16'd1, 1'b1); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        wait_outcomes(1, d0, e0);
        check(err_n - e0 == 1 && done_n == d0, "R10", "timeout pulse", err_n - e0, 1);
        begin
            int wr_seen = 0;
            for (int j = base; j < log_n; j++) if (log_we[j]) wr_seen++;
            check(wr_seen == 0, "R10", "writes after timeout", wr_seen, 0);
        end
        check(req_ready, "R10", "idle after timeout", req_ready, 1);
        repeat (20) @(negedge clk);   // let the drive model drain its busy count
        cfg_b1 = 0;
        run_cmd(1'b0, 1'b0, 48'h77, 16'd2, 1'b0, 0, 0);

        // R10 corner: limit 0 reached, but status not busy -> proceeds
        @(negedge clk);
        base = log_n; d0 = done_n; e0 = err_n; exp_n = 0;
        cfg_b1 = 0; cfg_b2 = 0; poll_limit = 16'd0;
        build(1'b1, 1'b0, 48'h99, 16'd3, 1'b1, 0, 0);
        drive(1'b1, 1'b0, 48'h99, 16'd3, 1'b1); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        wait_outcomes(1, d0, e0);
        compare_log(base);
        check(done_n - d0 == 1 && err_n == e0, "R10", "limit 0 not busy completes", done_n - d0, 1);

        // R11: requests while busy are ignored
        @(negedge clk);
        base = log_n; d0 = done_n; e0 = err_n; exp_n = 0; a0 = acc_n;
        cfg_b1 = 8; poll_limit = 16'hFFFF;
        build(1'b0, 1'b1, 48'h0_0200000, 16'd4, 1'b1, 8, 0);
        drive(1'b0, 1'b1, 48'h0_0200000, 16'd4, 1'b1); req_valid = 1'b1;
        @(negedge clk);
        drive(1'b1, 1'b0, 48'hFFFF_FFFF_FFFF, 16'hFFFF, 1'b0);
        for (int i = 0; i < 6; i++) begin
            check(!req_ready, "R11", "ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_outcomes(1, d0, e0);
        compare_log(base);
        check(acc_n - a0 == 1, "R11", "accepted requests", acc_n - a0, 1);

        // R9: back-to-back, second taken in the done cycle
        @(negedge clk);
        base = log_n; d0 = done_n; e0 = err_n; exp_n = 0; a0 = acc_n; ad0 = acc_on_done;
        cfg_b1 = 1; cfg_b2 = 0;
        build(1'b1, 1'b1, 48'h0_0000100, 16'd16, 1'b0, 1, 0);
        build(1'b0, 1'b0, 48'h0000_2000_0000, 16'd1, 1'b1, 1, 0);
        drive(1'b1, 1'b1, 48'h0_0000100, 16'd16, 1'b0); req_valid = 1'b1;
        @(negedge clk);
        drive(1'b0, 1'b0, 48'h0000_2000_0000, 16'd1, 1'b1);
        begin
            int n = 0;
            while (acc_n - a0 < 2 && n < 5000) begin @(negedge clk); n++; end
        end
        req_valid = 1'b0;
        wait_outcomes(2, d0, e0);
        compare_log(base);
        check(acc_on_done - ad0 == 1, "R9", "accept in done cycle", acc_on_done - ad0, 1);

        // Random mix
        for (int r = 0; r < 40; r++) begin
            logic [47:0] lba; logic [15:0] cnt;
            int m = int'($urandom_range(2, 0));
            if (m == 0) lba = {20'h0, 28'($urandom)};
            else if (m == 1) lba = {16'($urandom), 32'($urandom)};
            else lba = 48'h1000_0000 - 48'($urandom_range(3, 0)) - 48'd1;
            cnt = ($urandom_range(1, 0) == 1) ? 16'($urandom) : 16'($urandom_range(255, 1));
            run_cmd($urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, lba, cnt,
                    $urandom_range(1, 0) == 1, int'($urandom_range(2, 0)),
                    int'($urandom_range(2, 0)));
        end

        check(hold_viol == 0, "R12", "fields held while pending", hold_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule